// File: doc/BRIEF.md
# Delay-Slot Illegal Instruction Exception Unit

This unit sits next to the 16-bit instruction decoder of a pipelined 32-bit core that uses delayed branches. Each cycle the decoder presents one instruction together with a flag telling whether it occupies the slot after a delayed branch, a flag telling whether that branch was a return-from-exception, and a set of pre-decoded class flags. While the instruction is in a slot, the unit checks it against the forbidden classes. Two mask bits can relax the rules for the sleep instruction and for the slot after a return-from-exception.

When a forbidden slot instruction is found, the unit produces the whole exception-entry update in one registered cycle. The saved PC is rewound by one instruction so that it points back at the delayed branch. The saved status takes SR and the saved stack word takes R15. The event register takes the slot-fault code. SR is returned with its mode, bank and block bits forced to 1, and the new PC is the vector base plus the fixed slot-fault offset. A flush strobe marks that same cycle.

If exceptions are already blocked (SR block bit set), the unit raises a separate blocked strobe instead and leaves all saved state untouched. Outside a delay slot the unit never reacts.

Top module: `slot_fault_unit`

## Requirements
- R1: With `in_slot` low or `dec_valid` low, `flush_o` and `blocked_o` stay 0 on the next cycle, whatever the class flags say.
- R2: A valid slot instruction that has `is_undef` set, or whose `instr_code` equals 16'hFFFD, raises the exception.
- R3: A valid slot instruction with `is_pc_write` set (jumps, branches, calls, returns, trap, writes to SR, cache-block invalidate and prefetch) raises the exception.
- R4: A valid slot instruction with `is_priv` set raises the exception when SR bit 30 (mode) is 0. With SR bit 30 equal to 1 and no other flag set, nothing is raised.
- R5: A valid slot instruction with `is_pc_rel` set (PC-relative load or address-of) raises the exception.
- R6: A slot instruction with `is_sleep` set raises the exception when `mask_sleep_ok` is 0. When it is 1 and the mode is privileged, the instruction is accepted.
- R7: When `slot_of_rte` is 1 and `mask_rte_relax` is 0, any slot instruction without `is_nop` raises the exception. A slot instruction with `is_nop` set, or any instruction once `mask_rte_relax` is 1, raises nothing on that account.
- R8: Entry is registered: one cycle after the faulting decode, `flush_o` pulses for one cycle, with `spc_o` = `pc_in` − 2, `ssr_o` = `sr_in` and `sgr_o` = `r15_in`, all sampled at the faulting decode.
- R9: In the entry cycle `expevt_o` = 32'h000001A0, `sr_o` = `sr_in` with bits 30, 29 and 28 set, and `pc_o` = `vbr_in` + 32'h100.
- R10: If SR bit 28 (block) is 1 when a fault is found, `blocked_o` pulses one cycle later, `flush_o` stays 0 and every saved output keeps its value.
- R11: After reset every output is 0.
- R12: The saved outputs change only in an entry cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoder presents a valid instruction |
| in_slot | input | 1 | Instruction sits in a delay slot |
| slot_of_rte | input | 1 | The slot belongs to a return-from-exception |
| instr_code | input | 16 | Raw instruction code |
| is_undef | input | 1 | Pre-decoded: undefined instruction |
| is_pc_write | input | 1 | Pre-decoded: instruction changes PC |
| is_priv | input | 1 | Pre-decoded: privileged instruction |
| is_pc_rel | input | 1 | Pre-decoded: PC-relative load or address-of |
| is_sleep | input | 1 | Pre-decoded: sleep instruction |
| is_nop | input | 1 | Pre-decoded: no-operation |
| mask_sleep_ok | input | 1 | 1 allows sleep in a slot |
| mask_rte_relax | input | 1 | 1 lifts the NOP-only rule in a return slot |
| pc_in | input | 32 | PC of the decoded instruction |
| sr_in | input | 32 | Current status register |
| r15_in | input | 32 | Current stack pointer R15 |
| vbr_in | input | 32 | Vector base |
| flush_o | output | 1 | Entry strobe; pipeline flush request |
| blocked_o | output | 1 | Fault found while exceptions blocked |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved status |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 32 | Exception event code |
| sr_o | output | 32 | Status value to load at entry |
| pc_o | output | 32 | Vector PC |

## Verification
The assertions assume that the pre-decoded flags agree with each other. Sleep is also marked privileged, and a NOP carries no other class flag. They also assume that `sr_in`, `pc_in` and `vbr_in` are the values that belong to the decoded instruction in that cycle. The stimulus builds each vector from a named instruction kind, so sleep always comes with `is_priv` and NOP alone. Mode and block bits are set only through whole SR values chosen for the case. The vectors that exercise the relaxed masks are driven in privileged mode so that no second rule fires.

// File: rtl/slotfault_pkg.sv
package slotfault_pkg;
  localparam int unsigned XW = 32;

  // fault reasons, one bit each
  localparam int unsigned C_UNDEF = 0;
  localparam int unsigned C_PCW   = 1;
  localparam int unsigned C_PRIV  = 2;
  localparam int unsigned C_PCREL = 3;
  localparam int unsigned C_SLEEP = 4;
  localparam int unsigned C_RTE   = 5;
  localparam int unsigned N_CAUSE = 6;

  typedef struct packed {
    logic undef;
    logic pc_write;
    logic priv;
    logic pc_rel;
    logic sleep;
    logic nop;
  } insn_cls_t;

  // saved PC: step back over the delayed branch
  function automatic logic [XW-1:0] rewind_pc(logic [XW-1:0] pc, int unsigned bytes);
    return pc - XW'(bytes);
  endfunction

  function automatic logic [XW-1:0] vector_pc(logic [XW-1:0] base, logic [XW-1:0] ofs);
    return base + ofs;
  endfunction

  function automatic logic [XW-1:0] entry_sr(logic [XW-1:0] sr, int unsigned md,
                                             int unsigned rb, int unsigned bl);
    logic [XW-1:0] r;
    r = sr;
    r[md] = 1'b1;
    r[rb] = 1'b1;
    r[bl] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/slot_rule_check.sv
module slot_rule_check
  import slotfault_pkg::*;
#(
  parameter int unsigned    INSN_W     = 16,
  parameter logic [INSN_W-1:0] UNDEF_CODE = 16'hFFFD
) (
  input  logic              dec_valid,
  input  logic              in_slot,
  input  logic              slot_of_rte,
  input  logic [INSN_W-1:0] code,
  input  insn_cls_t         cls,
  input  logic              user_mode,
  input  logic              sleep_ok,
  input  logic              rte_relax,
  output logic              illegal
);
  logic [N_CAUSE-1:0] cause;
  logic               live;

  assign live = dec_valid & in_slot;

  always_comb begin
    cause          = '0;
    cause[C_UNDEF] = cls.undef | (code == UNDEF_CODE);
    cause[C_PCW]   = cls.pc_write;
    cause[C_PRIV]  = cls.priv & user_mode;
    cause[C_PCREL] = cls.pc_rel;
    cause[C_SLEEP] = cls.sleep & ~sleep_ok;
    cause[C_RTE]   = slot_of_rte & ~rte_relax & ~cls.nop;
  end

  assign illegal = live & (|cause);
endmodule

// File: rtl/slot_entry_calc.sv
module slot_entry_calc
  import slotfault_pkg::*;
#(
  parameter int unsigned    INSN_BYTES = 2,
  parameter logic [XW-1:0]  VEC_OFS    = 32'h0000_0100,
  parameter int unsigned    MD_BIT     = 30,
  parameter int unsigned    RB_BIT     = 29,
  parameter int unsigned    BL_BIT     = 28
) (
  input  logic [XW-1:0] pc_in,
  input  logic [XW-1:0] sr_in,
  input  logic [XW-1:0] vbr_in,
  output logic [XW-1:0] spc_nx,
  output logic [XW-1:0] sr_nx,
  output logic [XW-1:0] pc_nx
);
  assign spc_nx = rewind_pc(pc_in, INSN_BYTES);
  assign sr_nx  = entry_sr(sr_in, MD_BIT, RB_BIT, BL_BIT);
  assign pc_nx  = vector_pc(vbr_in, VEC_OFS);
endmodule

// File: rtl/slot_fault_unit.sv
module slot_fault_unit
  import slotfault_pkg::*;
#(
  parameter int unsigned       INSN_W     = 16,
  parameter int unsigned       INSN_BYTES = INSN_W / 8,
  parameter logic [INSN_W-1:0] UNDEF_CODE = 16'hFFFD,
  parameter logic [XW-1:0]     EVT_CODE   = 32'h0000_01A0,
  parameter logic [XW-1:0]     VEC_OFS    = 32'h0000_0100,
  parameter int unsigned       MD_BIT     = 30,
  parameter int unsigned       RB_BIT     = 29,
  parameter int unsigned       BL_BIT     = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic              in_slot,
  input  logic              slot_of_rte,
  input  logic [INSN_W-1:0] instr_code,
  input  logic              is_undef,
  input  logic              is_pc_write,
  input  logic              is_priv,
  input  logic              is_pc_rel,
  input  logic              is_sleep,
  input  logic              is_nop,
  input  logic              mask_sleep_ok,
  input  logic              mask_rte_relax,
  input  logic [XW-1:0]     pc_in,
  input  logic [XW-1:0]     sr_in,
  input  logic [XW-1:0]     r15_in,
  input  logic [XW-1:0]     vbr_in,
  output logic              flush_o,
  output logic              blocked_o,
  output logic [XW-1:0]     spc_o,
  output logic [XW-1:0]     ssr_o,
  output logic [XW-1:0]     sgr_o,
  output logic [XW-1:0]     expevt_o,
  output logic [XW-1:0]     sr_o,
  output logic [XW-1:0]     pc_o
);
  insn_cls_t     cls;
  logic          slot_illegal;   // fault found this cycle
  logic          take_entry;     // fault and exceptions open
  logic          take_block;     // fault while blocked
  logic [XW-1:0] spc_nx, sr_nx, pc_nx;

  assign cls = '{undef: is_undef, pc_write: is_pc_write, priv: is_priv,
                 pc_rel: is_pc_rel, sleep: is_sleep, nop: is_nop};

  slot_rule_check #(.INSN_W(INSN_W), .UNDEF_CODE(UNDEF_CODE)) u_rules (
    .dec_valid  (dec_valid),
    .in_slot    (in_slot),
    .slot_of_rte(slot_of_rte),
    .code       (instr_code),
    .cls        (cls),
    .user_mode  (~sr_in[MD_BIT]),
    .sleep_ok   (mask_sleep_ok),
    .rte_relax  (mask_rte_relax),
    .illegal    (slot_illegal)
  );

  slot_entry_calc #(.INSN_BYTES(INSN_BYTES), .VEC_OFS(VEC_OFS),
                    .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT)) u_calc (
    .pc_in (pc_in),
    .sr_in (sr_in),
    .vbr_in(vbr_in),
    .spc_nx(spc_nx),
    .sr_nx (sr_nx),
    .pc_nx (pc_nx)
  );

  assign take_entry = slot_illegal & ~sr_in[BL_BIT];
  assign take_block = slot_illegal &  sr_in[BL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_o   <= 1'b0;
      blocked_o <= 1'b0;
      spc_o     <= '0;
      ssr_o     <= '0;
      sgr_o     <= '0;
      expevt_o  <= '0;
      sr_o      <= '0;
      pc_o      <= '0;
    end else begin
      flush_o   <= take_entry;
      blocked_o <= take_block;
      if (take_entry) begin
        spc_o    <= spc_nx;
        ssr_o    <= sr_in;
        sgr_o    <= r15_in;
        expevt_o <= EVT_CODE;
        sr_o     <= sr_nx;
        pc_o     <= pc_nx;
      end
    end
  end

  // R1: nothing happens outside a valid slot
  p_quiet_outside_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_slot || !dec_valid) |=> (!flush_o && !blocked_o));

  // R4: privileged instruction in user mode with exceptions open enters
  p_user_priv_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && in_slot && is_priv && !sr_in[MD_BIT] && !sr_in[BL_BIT]) |=> flush_o);

  // R8: saved PC and saved state come from the faulting decode
  p_saved_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (spc_o == $past(pc_in) - XW'(INSN_BYTES)) && (ssr_o == $past(sr_in))
                && (sgr_o == $past(r15_in)));

  // R9: event code, forced SR bits and vector PC in the entry cycle
  p_entry_values_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (expevt_o == EVT_CODE) && sr_o[MD_BIT] && sr_o[RB_BIT] && sr_o[BL_BIT]
                && (pc_o == $past(vbr_in) + VEC_OFS));

  // R10: blocked fault never enters and leaves saved state alone
  p_blocked_no_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_o |-> (!flush_o && $stable(spc_o) && $stable(ssr_o) && $stable(pc_o)));

  // R12: saved outputs change only on entry
  p_hold_between_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |-> ($stable(spc_o) && $stable(sgr_o) && $stable(sr_o) && $stable(expevt_o)));
endmodule

// File: tb/test_slot_fault_unit.sv
module test_slot_fault_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 0, in_slot = 0, slot_of_rte = 0;
  logic [15:0] instr_code = 16'h0009;
  logic        is_undef = 0, is_pc_write = 0, is_priv = 0, is_pc_rel = 0, is_sleep = 0, is_nop = 0;
  logic        mask_sleep_ok = 0, mask_rte_relax = 0;
  logic [31:0] pc_in = 0, sr_in = 0, r15_in = 0, vbr_in = 0;
  logic        flush_o, blocked_o;
  logic [31:0] spc_o, ssr_o, sgr_o, expevt_o, sr_o, pc_o;

  always #(CLK_P/2) clk = ~clk;

  slot_fault_unit i_slot_fault_unit (.*);

  typedef struct {
    logic        fl, bk;
    logic [31:0] spc, ssr, sgr, evt, sr, pc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  exp_t m;  // bench model of held outputs

  typedef enum {K_ADD, K_NOP, K_UNDEF, K_FFFD, K_BRANCH, K_PRIV, K_PCREL, K_SLEEP} kind_t;

  localparam logic [31:0] SR_PRIV = 32'h4000_00F0;
  localparam logic [31:0] SR_USER = 32'h0000_0013;
  localparam logic [31:0] SR_BLK  = 32'h5000_0001;

  task automatic apply(input string tag, input logic v, input logic slot, input logic rte,
                       input kind_t k, input logic m_sl, input logic m_rt,
                       input logic [31:0] pc, input logic [31:0] sr,
                       input logic [31:0] r15, input logic [31:0] vbr);
    logic bad;
    exp_t e;
    @(negedge clk);
    dec_valid = v; in_slot = slot; slot_of_rte = rte;
    mask_sleep_ok = m_sl; mask_rte_relax = m_rt;
    pc_in = pc; sr_in = sr; r15_in = r15; vbr_in = vbr;
    {is_undef, is_pc_write, is_priv, is_pc_rel, is_sleep, is_nop} = '0;
    instr_code = 16'h300C;
    case (k)
      K_NOP:    begin is_nop = 1; instr_code = 16'h0009; end
      K_UNDEF:  begin is_undef = 1; instr_code = 16'hFFFE; end
      K_FFFD:   instr_code = 16'hFFFD;
      K_BRANCH: begin is_pc_write = 1; instr_code = 16'hA010; end
      K_PRIV:   begin is_priv = 1; instr_code = 16'h4E0E; end
      K_PCREL:  begin is_pc_rel = 1; instr_code = 16'hC704; end
      K_SLEEP:  begin is_sleep = 1; is_priv = 1; instr_code = 16'h001B; end
      default:  ;
    endcase
    // bench's own legality rules
    bad = v && slot && (k == K_UNDEF || k == K_FFFD || k == K_BRANCH || k == K_PCREL ||
          ((k == K_PRIV || k == K_SLEEP) && !sr[30]) || (k == K_SLEEP && !m_sl) ||
          (rte && !m_rt && k != K_NOP));
    e = m;
    e.fl = bad && !sr[28];
    e.bk = bad && sr[28];
    if (e.fl) begin
      e.spc = pc + 32'hFFFF_FFFE; e.ssr = sr; e.sgr = r15; e.evt = 32'h1A0;
      e.sr = sr | 32'h7000_0000; e.pc = vbr + 32'h100;
    end
    e.tag = tag;
    m = e;
    q.push_back(e);
  endtask

  task automatic cmp(input exp_t e);
    n_chk++;
    if ({flush_o, blocked_o} !== {e.fl, e.bk} || spc_o !== e.spc || ssr_o !== e.ssr ||
        sgr_o !== e.sgr || expevt_o !== e.evt || sr_o !== e.sr || pc_o !== e.pc) begin
      n_bad++;
      $display("FAIL %s: got fl=%b bk=%b spc=%h ssr=%h sgr=%h evt=%h sr=%h pc=%h exp fl=%b bk=%b spc=%h ssr=%h sgr=%h evt=%h sr=%h pc=%h",
        e.tag, flush_o, blocked_o, spc_o, ssr_o, sgr_o, expevt_o, sr_o, pc_o,
        e.fl, e.bk, e.spc, e.ssr, e.sgr, e.evt, e.sr, e.pc);
    end
  endtask

  // monitor: one result per applied vector, a quarter period after the edge
  initial forever begin
    @(posedge clk);
    #(CLK_P/4);
    if (q.size() > 0) cmp(q.pop_front());
  end

  initial begin
    #(CLK_P*4000);
    n_bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m = '{fl: 0, bk: 0, spc: 0, ssr: 0, sgr: 0, evt: 0, sr: 0, pc: 0, tag: ""};
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    m.tag = "R11 reset";
    cmp(m);
    @(negedge clk); rst_n = 1;

    apply("R1 branch outside slot", 1, 0, 0, K_BRANCH, 0, 0, 32'h1000, SR_USER, 32'h11, 32'h8000_0000);
    apply("R1 valid low in slot",   0, 1, 1, K_UNDEF,  0, 0, 32'h1004, SR_USER, 32'h12, 32'h8000_0000);
    apply("R2 undef flag",          1, 1, 0, K_UNDEF,  0, 0, 32'h2002, SR_PRIV, 32'h21, 32'h8000_0000);
    apply("R12 hold after entry",   1, 0, 0, K_ADD,    0, 0, 32'h2004, SR_PRIV, 32'h22, 32'h9000_0000);
    apply("R2 code FFFD",           1, 1, 0, K_FFFD,   1, 1, 32'h3000, SR_USER, 32'h31, 32'hA000_0000);
    apply("R3 pc write",            1, 1, 0, K_BRANCH, 1, 1, 32'h0000_0000, SR_PRIV, 32'h41, 32'h0000_0F00);
    apply("R4 priv user mode",      1, 1, 0, K_PRIV,   1, 1, 32'h4400, SR_USER, 32'h51, 32'h1234_0000);
    apply("R4 priv in priv mode",   1, 1, 0, K_PRIV,   1, 1, 32'h4500, SR_PRIV, 32'h52, 32'h1111_0000);
    apply("R5 pc relative",         1, 1, 0, K_PCREL,  1, 1, 32'h5550, SR_PRIV, 32'h61, 32'hFFFF_FF80);
    apply("R6 sleep mask 0",        1, 1, 0, K_SLEEP,  0, 1, 32'h6000, SR_PRIV, 32'h71, 32'h2000_0000);
    apply("R6 sleep mask 1",        1, 1, 0, K_SLEEP,  1, 1, 32'h6100, SR_PRIV, 32'h72, 32'h2100_0000);
    apply("R7 rte slot add mask 0", 1, 1, 1, K_ADD,    1, 0, 32'h7000, SR_PRIV, 32'h81, 32'h3000_0000);
    apply("R7 rte slot nop mask 0", 1, 1, 1, K_NOP,    1, 0, 32'h7100, SR_PRIV, 32'h82, 32'h3100_0000);
    apply("R7 rte slot add mask 1", 1, 1, 1, K_ADD,    1, 1, 32'h7200, SR_PRIV, 32'h83, 32'h3200_0000);
    apply("R10 blocked fault",      1, 1, 0, K_BRANCH, 1, 1, 32'h8000, SR_BLK,  32'h91, 32'h4000_0000);
    apply("R10 blocked user priv",  1, 1, 0, K_PCREL,  1, 1, 32'h8100, 32'h1000_0000, 32'h92, 32'h4100_0000);
    apply("R8 R9 entry after block",1, 1, 0, K_UNDEF,  1, 1, 32'h9002, 32'h0000_00A5, 32'hDEAD, 32'h8800_0000);
    apply("R12 idle slot legal",    1, 1, 0, K_ADD,    1, 1, 32'h9100, SR_USER, 32'hBEEF, 32'h9900_0000);
    apply("R12 idle no slot",       0, 0, 0, K_ADD,    0, 0, 32'h9200, 32'hFFFF_FFFF, 32'h0, 32'h0);
    apply("R8 back to back 1",      1, 1, 0, K_BRANCH, 0, 0, 32'hA000, SR_USER, 32'hA1, 32'h5000_0000);
    apply("R8 back to back 2",      1, 1, 0, K_PCREL,  0, 0, 32'hA002, SR_PRIV, 32'hA2, 32'h5100_0000);
    apply("R1 final idle",          0, 0, 0, K_ADD,    0, 0, 32'h0,    32'h0,   32'h0,  32'h0);
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule